// File: doc/BRIEF.md
# Two-Way Data Address Translation Buffer

This block translates 64-bit effective addresses into real addresses for a data cache, using fixed 4 KiB pages. It holds 128 translations, organised as two ways of 64 sets. A lookup port accepts an effective address and a translation-enable flag. One cycle later it returns whether the access may proceed, whether the buffer hit, which way hit, and the real address. With translation disabled, the effective address is returned unchanged and the arrays are not consulted.

A single maintenance command, carrying two 64-bit operands (a control/address word and an entry word), does one of three jobs. It can wipe every translation, drop the one translation for a given page, or install a translation whose real page number and valid flag are taken from a radix-style page-table entry. A missed lookup with translation enabled is reported as not performed; no exception signal exists.

Top module: `dtlb_xlate`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every entry is invalid, rsp_valid is 0, and a translated lookup of any address misses.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with lk_req high, and 0 otherwise; the response fields are updated only on a lookup.
- R3: A lookup with lk_xlate_en = 0 returns rsp_ok = 1, rsp_hit = 0, rsp_way = 0 and rsp_ra equal to lk_ea, even when a matching entry is present.
- R4: A translated lookup that hits returns rsp_ok = 1, rsp_hit = 1, the hit way in rsp_way, and rsp_ra = {8 zero bits, stored 44-bit real page number, lk_ea[11:0]}.
- R5: A translated lookup that misses returns rsp_ok = 0, rsp_hit = 0, rsp_way = 0 and rsp_ra = 0.
- R6: A command whose mt_rb bit 10 or bit 11 is 1 invalidates every entry of both ways in one cycle, whatever bit 9 holds; no entry is written.
- R7: A command with mt_rb[11:9] = 000 invalidates only the entry whose page equals mt_rb[63:12]; other entries, including the other way of the same set, stay valid.
- R8: A command with mt_rb[11:9] = 001 writes the entry for page mt_rb[63:12], with valid flag mt_rs[63] and real page number mt_rs[55:12]; when mt_rs[63] = 0, that page then misses.
- R9: An entry write goes to the way already holding that page, if any. Otherwise it goes to an invalid way (way 0 first). Otherwise it goes to the least recently used way of the set, where both translated hits and writes count as use.
- R10: The set index is page bits ea[17:12] and the tag is ea[63:18]; pages with different indices never displace each other, and two pages of one set are held in both ways at once.
- R11: A lookup issued in the same cycle as a maintenance command sees the array contents from before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_xlate_en | input | 1 | 1: translate through the buffer; 0: real mode |
| lk_ea | input | 64 | Effective address of the lookup |
| mt_req | input | 1 | Maintenance command this cycle |
| mt_rb | input | 64 | Command word: page in [63:12], function in [11:9] |
| mt_rs | input | 64 | Entry word: valid in [63], real page number in [55:12] |
| rsp_valid | output | 1 | Response fields below belong to last cycle's lookup |
| rsp_ok | output | 1 | Access may be performed |
| rsp_hit | output | 1 | Translation came from a buffer hit |
| rsp_way | output | 1 | Way that hit |
| rsp_ra | output | 64 | Real address |

## Verification
Every lookup result is registered once, so rsp_valid and the response fields are due at the first rising edge after the edge that sampled lk_req. The bench drives inputs on the falling edge and reads the response on the next falling edge, half a cycle after the result was latched. A maintenance command takes effect at the edge that samples it, so the next lookup, driven on the following falling edge, already sees the new contents. The same-cycle case drives both ports in one cycle and expects the old contents in the response.

// File: rtl/dtlb_pkg.sv
// Package: shared command encoding for the data translation buffer.
// Assumes the three function bits are taken from the command word by the caller.
package dtlb_pkg;

    typedef enum logic [1:0] {
        CMD_KILL_ONE = 2'd0,
        CMD_LOAD     = 2'd1,
        CMD_KILL_ALL = 2'd2
    } tlb_cmd_e;

    // Decode the three function bits [11:9]; a wipe takes priority over a load.
    function automatic tlb_cmd_e decode_cmd(input logic [2:0] fn);
        if (fn[1] || fn[2])
            return CMD_KILL_ALL;
        else if (fn[0])
            return CMD_LOAD;
        else
            return CMD_KILL_ONE;
    endfunction

endpackage

// File: rtl/dtlb_way.sv
// Module: one way of the translation buffer.
// Holds a valid vector, a tag array and a real-page array, indexed by set.
// Has a read port for lookups and a read/write port for maintenance.
// Assumes the caller never asserts flush_all, kill_one and wr_en together.
module dtlb_way #(
    parameter int SET_BITS = 6,
    parameter int TAG_W    = 46,
    parameter int RPN_W    = 44
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] lk_idx,
    input  logic [TAG_W-1:0]    lk_tag,
    output logic                lk_hit,
    output logic [RPN_W-1:0]    lk_rpn,
    input  logic [SET_BITS-1:0] mt_idx,
    input  logic [TAG_W-1:0]    mt_tag,
    output logic                mt_hit,
    output logic                mt_used,
    input  logic                flush_all,
    input  logic                kill_one,
    input  logic                wr_en,
    input  logic                wr_valid,
    input  logic [RPN_W-1:0]    wr_rpn
);
    localparam int SETS = 1 << SET_BITS;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [RPN_W-1:0] rpn_q [SETS];

    // Lookup compare on the lookup index.
    always_comb begin
        lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_rpn = rpn_q[lk_idx];
    end

    // Maintenance compare and occupancy on the maintenance index.
    always_comb begin
        mt_used = vld_q[mt_idx];
        mt_hit  = vld_q[mt_idx] && (tag_q[mt_idx] == mt_tag);
    end

    // Valid bits: reset, wipe, single drop or write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (flush_all)
            vld_q <= '0;
        else if (kill_one)
            vld_q[mt_idx] <= 1'b0;
        else if (wr_en)
            vld_q[mt_idx] <= wr_valid;
    end

    // Tag and real-page storage, written only by an entry load.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[mt_idx] <= mt_tag;
            rpn_q[mt_idx] <= wr_rpn;
        end
    end

    assert_wipe_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_q == '0));

    assert_drop_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kill_one |=> !vld_q[$past(mt_idx)]);

    assert_load_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush_all && !kill_one) |=> (vld_q[$past(mt_idx)] == $past(wr_valid)));

endmodule

// File: rtl/dtlb_lru.sv
// Module: per-set one-bit replacement state for a two-way buffer.
// Each bit names the way to evict next. It is updated by a translated hit
// and by an entry write. When both update the same set in one cycle, the write wins.
module dtlb_lru #(
    parameter int SET_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_en,
    input  logic [SET_BITS-1:0] hit_idx,
    input  logic                hit_way,
    input  logic                wr_en,
    input  logic [SET_BITS-1:0] wr_idx,
    input  logic                wr_way,
    input  logic [SET_BITS-1:0] vic_idx,
    output logic                vic_way
);
    localparam int SETS = 1 << SET_BITS;

    logic [SETS-1:0] lru_q;

    // Report the eviction candidate for the maintenance set.
    always_comb vic_way = lru_q[vic_idx];

    // Point each touched set at the way that was not just used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (hit_en)
                lru_q[hit_idx] <= ~hit_way;
            if (wr_en)
                lru_q[wr_idx] <= ~wr_way;
        end
    end

    assert_write_not_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lru_q[$past(wr_idx)] != $past(wr_way)));

endmodule

// File: rtl/dtlb_xlate.sv
// Module: two-way data address translation buffer (top).
// Translates through 4 KiB pages, or passes addresses through in real mode.
// Serves a maintenance command that wipes all entries, drops one page or loads one entry.
// Assumes two ways; the lookup response is registered one cycle after lk_req.
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int PG_BITS   = 12,
    parameter int SET_BITS  = 6,
    parameter int CMD_LSB   = 9,
    parameter int RPN_LSB   = 12,
    parameter int RPN_MSB   = 55,
    parameter int PTE_V_BIT = 63
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_req,
    input  logic            lk_xlate_en,
    input  logic [EA_W-1:0] lk_ea,
    input  logic            mt_req,
    input  logic [EA_W-1:0] mt_rb,
    input  logic [EA_W-1:0] mt_rs,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic            rsp_hit,
    output logic            rsp_way,
    output logic [EA_W-1:0] rsp_ra
);
    localparam int WAYS   = 2;
    localparam int TAG_W  = EA_W - PG_BITS - SET_BITS;
    localparam int RPN_W  = RPN_MSB - RPN_LSB + 1;
    localparam int RA_PAD = EA_W - RPN_W - PG_BITS;

    // Field extraction.
    logic [SET_BITS-1:0] lk_idx, mt_idx;
    logic [TAG_W-1:0]    lk_tag, mt_tag;
    logic [RPN_W-1:0]    pte_rpn;
    logic                pte_v;
    tlb_cmd_e            cmd;

    always_comb begin
        lk_idx  = lk_ea[PG_BITS +: SET_BITS];
        lk_tag  = lk_ea[EA_W-1 -: TAG_W];
        mt_idx  = mt_rb[PG_BITS +: SET_BITS];
        mt_tag  = mt_rb[EA_W-1 -: TAG_W];
        pte_rpn = mt_rs[RPN_MSB:RPN_LSB];
        pte_v   = mt_rs[PTE_V_BIT];
        cmd     = decode_cmd(mt_rb[CMD_LSB +: 3]);
    end

    logic unused_bits;
    assign unused_bits = ^{mt_rb[CMD_LSB-1:0], mt_rs[PTE_V_BIT-1:RPN_MSB+1], mt_rs[RPN_LSB-1:0]};

    // Per-way signals.
    logic [WAYS-1:0]  lk_hit_v, mt_hit_v, mt_used_v, kill_v, wr_v;
    logic [RPN_W-1:0] way_rpn [WAYS];
    logic             flush_all, do_load, vic_way, load_way;

    // Choose the way an entry load lands in: same page, then empty, then LRU.
    always_comb begin
        if (|mt_hit_v)
            load_way = mt_hit_v[1];
        else if (!mt_used_v[0])
            load_way = 1'b0;
        else if (!mt_used_v[1])
            load_way = 1'b1;
        else
            load_way = vic_way;
    end

    // Turn the decoded command into per-way strobes.
    always_comb begin
        flush_all = mt_req && (cmd == CMD_KILL_ALL);
        do_load   = mt_req && (cmd == CMD_LOAD);
        for (int w = 0; w < WAYS; w++) begin
            kill_v[w] = mt_req && (cmd == CMD_KILL_ONE) && mt_hit_v[w];
            wr_v[w]   = do_load && (load_way == w[0]);
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        dtlb_way #(
            .SET_BITS(SET_BITS),
            .TAG_W   (TAG_W),
            .RPN_W   (RPN_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (lk_idx),
            .lk_tag   (lk_tag),
            .lk_hit   (lk_hit_v[g]),
            .lk_rpn   (way_rpn[g]),
            .mt_idx   (mt_idx),
            .mt_tag   (mt_tag),
            .mt_hit   (mt_hit_v[g]),
            .mt_used  (mt_used_v[g]),
            .flush_all(flush_all),
            .kill_one (kill_v[g]),
            .wr_en    (wr_v[g]),
            .wr_valid (pte_v),
            .wr_rpn   (pte_rpn)
        );
    end

    // Lookup result before the response register.
    logic             lk_any, lk_way, lk_touch;
    logic [RPN_W-1:0] lk_rpn;

    always_comb begin
        lk_any   = |lk_hit_v;
        lk_way   = lk_hit_v[1];
        lk_rpn   = way_rpn[lk_way];
        lk_touch = lk_req && lk_xlate_en && lk_any;
    end

    dtlb_lru #(
        .SET_BITS(SET_BITS)
    ) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_en (lk_touch),
        .hit_idx(lk_idx),
        .hit_way(lk_way),
        .wr_en  (do_load),
        .wr_idx (mt_idx),
        .wr_way (load_way),
        .vic_idx(mt_idx),
        .vic_way(vic_way)
    );

    // Response register: real mode, hit or miss, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= 1'b0;
            rsp_ra    <= '0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) begin
                if (!lk_xlate_en) begin
                    rsp_ok  <= 1'b1;
                    rsp_hit <= 1'b0;
                    rsp_way <= 1'b0;
                    rsp_ra  <= lk_ea;
                end else if (lk_any) begin
                    rsp_ok  <= 1'b1;
                    rsp_hit <= 1'b1;
                    rsp_way <= lk_way;
                    rsp_ra  <= {{RA_PAD{1'b0}}, lk_rpn, lk_ea[PG_BITS-1:0]};
                end else begin
                    rsp_ok  <= 1'b0;
                    rsp_hit <= 1'b0;
                    rsp_way <= 1'b0;
                    rsp_ra  <= '0;
                end
            end
        end
    end

    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_v));

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    assert_no_resp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    assert_real_mode_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_xlate_en) |=> (rsp_ok && !rsp_hit && rsp_ra == $past(lk_ea)));

    assert_hit_means_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_ok);

    assert_miss_zero_ra_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_ra == '0 && !rsp_way));

endmodule

// File: tb/dtlb_xlate_test.sv
module dtlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_xlate_en = 1'b0;
    logic [63:0] lk_ea = '0, mt_rb = '0, mt_rs = '0;
    logic        mt_req = 1'b0;
    logic        rsp_valid, rsp_ok, rsp_hit, rsp_way;
    logic [63:0] rsp_ra;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    dtlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_xlate_en(lk_xlate_en), .lk_ea(lk_ea),
        .mt_req(mt_req), .mt_rb(mt_rb), .mt_rs(mt_rs), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_ra(rsp_ra)
    );

    always #5 clk = ~clk;

    function automatic logic [51:0] pg(input logic [45:0] tg, input logic [5:0] ix);
        return {tg, ix};
    endfunction
    function automatic logic [63:0] ra_of(input logic [43:0] rpn, input logic [11:0] off);
        return {8'h00, rpn, off};
    endfunction
    function automatic logic [63:0] pte(input logic v, input logic [43:0] rpn);
        return {v, 7'h00, rpn, 12'h000};
    endfunction

    task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue a command; it takes effect at the next rising edge.
    task automatic cmd(input logic [51:0] page, input logic [11:0] fn, input logic [63:0] rs);
        @(negedge clk);
        mt_req = 1'b1; mt_rb = {page, fn}; mt_rs = rs;
        @(negedge clk);
        mt_req = 1'b0;
    endtask

    // Issue a lookup and compare {valid, ok, hit, way, ra} one cycle later.
    task automatic look(input string req, input logic [63:0] ea, input logic xl,
                        input logic e_ok, input logic e_hit, input logic e_way, input logic [63:0] e_ra);
        @(negedge clk);
        lk_req = 1'b1; lk_ea = ea; lk_xlate_en = xl;
        @(negedge clk);
        lk_req = 1'b0;
        check(req, {1'b0, rsp_valid, rsp_ok, rsp_hit, rsp_way, rsp_ra},
                   {1'b0, 1'b1, e_ok, e_hit, e_way, e_ra});
    endtask

    localparam logic [11:0] F_LOAD = 12'h200, F_DROP = 12'h000, F_WIPE = 12'h800, F_WIPE9 = 12'h600;
    localparam logic [43:0] RA_A = 44'h123_4567_89AB, RA_B = 44'h000_0000_0BBB, RA_C = 44'hCCC,
                            RA_D = 44'hDDD, RA_D2 = 44'hD2D, RA_E = 44'hEEE;
    logic [51:0] pa, pb, pc, pd, pe, pf, px;

    task automatic t_reset;
        check("R1 rsp_valid after reset", {67'b0, rsp_valid}, 68'b0);
        look("R1 lookup after reset", {pa, 12'h010}, 1'b1, 0, 0, 0, 64'h0);
        look("R5 miss at other set", {pc, 12'hFFF}, 1'b1, 0, 0, 0, 64'h0);
    endtask

    task automatic t_fill;
        cmd(pa, F_LOAD, pte(1'b1, RA_A));
        look("R4 hit after load", {pa, 12'hABC}, 1'b1, 1, 1, 0, ra_of(RA_A, 12'hABC));
        look("R3 real mode bypass", 64'hDEAD_BEEF_1234_5678, 1'b0, 1, 0, 0, 64'hDEAD_BEEF_1234_5678);
        look("R3 real mode ignores entry", {pa, 12'h004}, 1'b0, 1, 0, 0, {pa, 12'h004});
        @(negedge clk);
        check("R2 valid one cycle only", {67'b0, rsp_valid}, 68'b0);
        cmd(pb, F_LOAD, pte(1'b1, RA_B));
        cmd(pc, F_LOAD, pte(1'b1, RA_C));
        look("R10 second page same set way1", {pb, 12'h001}, 1'b1, 1, 1, 1, ra_of(RA_B, 12'h001));
        look("R10 other set unaffected", {pc, 12'h002}, 1'b1, 1, 1, 0, ra_of(RA_C, 12'h002));
        look("R10 first page kept way0", {pa, 12'h003}, 1'b1, 1, 1, 0, ra_of(RA_A, 12'h003));
    endtask

    task automatic t_lru;
        // A was used last, so D evicts B (way1); then E evicts A (way0).
        cmd(pd, F_LOAD, pte(1'b1, RA_D));
        cmd(pe, F_LOAD, pte(1'b1, RA_E));
        look("R9 lru evicted B", {pb, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
        look("R9 lru evicted A", {pa, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
        look("R9 D in way1", {pd, 12'h111}, 1'b1, 1, 1, 1, ra_of(RA_D, 12'h111));
        look("R9 E in way0", {pe, 12'h222}, 1'b1, 1, 1, 0, ra_of(RA_E, 12'h222));
        cmd(pd, F_LOAD, pte(1'b1, RA_D2));
        look("R9 reload same way", {pd, 12'h333}, 1'b1, 1, 1, 1, ra_of(RA_D2, 12'h333));
        look("R9 reload keeps other way", {pe, 12'h444}, 1'b1, 1, 1, 0, ra_of(RA_E, 12'h444));
    endtask

    task automatic t_drop;
        cmd(pd, F_DROP, 64'h0);
        look("R7 dropped page misses", {pd, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
        look("R7 sibling survives", {pe, 12'h555}, 1'b1, 1, 1, 0, ra_of(RA_E, 12'h555));
        cmd(px, F_DROP, 64'h0);
        look("R7 absent page drop harmless", {pe, 12'h556}, 1'b1, 1, 1, 0, ra_of(RA_E, 12'h556));
        look("R7 other set survives", {pc, 12'h557}, 1'b1, 1, 1, 0, ra_of(RA_C, 12'h557));
        cmd(pf, F_LOAD, pte(1'b0, 44'hFFF));
        look("R8 invalid pte not usable", {pf, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
    endtask

    task automatic t_wipe;
        cmd(px, F_WIPE, 64'h0);
        look("R6 wipe clears E", {pe, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
        look("R6 wipe clears C", {pc, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
        cmd(pc, F_LOAD, pte(1'b1, RA_C));
        look("R8 reload after wipe", {pc, 12'h0F0}, 1'b1, 1, 1, 0, ra_of(RA_C, 12'h0F0));
        cmd(pf, F_WIPE9, pte(1'b1, 44'h777));
        look("R6 bit10 wipes despite bit9", {pc, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
        look("R6 bit10 command loads nothing", {pf, 12'h000}, 1'b1, 0, 0, 0, 64'h0);
    endtask

    task automatic t_same_cycle;
        cmd(pe, F_LOAD, pte(1'b1, RA_E));
        @(negedge clk);
        lk_req = 1'b1; lk_ea = {pe, 12'h0AA}; lk_xlate_en = 1'b1;
        mt_req = 1'b1; mt_rb = {px, F_WIPE}; mt_rs = '0;
        @(negedge clk);
        lk_req = 1'b0; mt_req = 1'b0;
        check("R11 lookup sees old contents", {1'b0, rsp_valid, rsp_ok, rsp_hit, rsp_way, rsp_ra},
              {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, ra_of(RA_E, 12'h0AA)});
        look("R11 wipe applied afterwards", {pe, 12'h0AA}, 1'b1, 0, 0, 0, 64'h0);
    endtask

    initial begin
        pa = pg(46'h1, 6'd5);  pb = pg(46'h2, 6'd5);  pc = pg(46'h1, 6'd40);
        pd = pg(46'h3, 6'd5);  pe = pg(46'h4, 6'd5);  pf = pg(46'h9, 6'd7);
        px = pg(46'h77, 6'd5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_lru();
        t_drop();
        t_wipe();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule